// File: doc/BRIEF.md
# Wait/Hold Clock Domain Divider

This block derives a domain clock from a selected input clock by an integer ratio of two or more. Each output period is split into a high phase and a low phase. Their lengths come from two programmable counts, a wait count and a hold count. The high phase lasts wait + 1 input cycles and the low phase lasts hold + 1 input cycles, so one period is wait + hold + 2 input cycles. A bypass setting passes the input clock straight through, and the counts are then ignored.

Software writes new counts and the bypass setting into a staging register. None of these values reach the divider until a write also sets the commit bit. The commit bit then reads back as 1 until the staged values have been loaded, and it clears itself. Loading happens only at the end of an output period, so the output never shows a shortened pulse.

To reach a ratio R, program wait = R/2 − 1 (integer division) and hold = R − wait − 2. This gives a duty cycle as close to 50% as an integer split allows. The count width CNT_W sets the ratio range, which runs from 2 to 2^(CNT_W+1). A narrower variant uses CNT_W = 3.

Top module: `wh_clk_div`

## Requirements
- R1: After a synchronous reset the readback word is all zero (wait 0, hold 0, bypass 0, commit 0), and the output divides by 2: one input cycle high, one input cycle low.
- R2: With bypass inactive, the output is high for wait + 1 input cycles and then low for hold + 1 input cycles, repeating.
- R3: A write with the commit bit clear updates the readback fields but leaves the active division unchanged. Register layout: wait in bits [CNT_W-1:0], hold in bits [2*CNT_W-1:CNT_W], bypass in bit 2*CNT_W, commit in bit 2*CNT_W+1.
- R4: After a write with the commit bit set, the commit bit reads 1. It reads 0 again once the staged values have become active.
- R5: A committed change takes effect only after the current output period has finished with its old high and low lengths. The new lengths start with a full high phase.
- R6: While bypass is active, the output follows the input clock, whatever the counts are.
- R7: Bypass is entered and left only through a commit. When bypass is left, the divided output starts with a full high phase of wait + 1 cycles.
- R8: Programming wait = R/2 − 1 and hold = R − wait − 2 gives a period of R cycles, R/2 of them high. This holds over the full range 2 to 2^(CNT_W+1).
- R9: A commit write may land in the same cycle as the period boundary that loads an earlier pending commit. In that case the earlier values are loaded, and the new values stay pending until the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected input clock; also clocks all control logic |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2*CNT_W+2 | Configuration write word (wait, hold, bypass, commit) |
| cfg_rdata | output | 2*CNT_W+2 | Staged wait, hold and bypass, with the pending-commit flag on top |
| clk_out | output | 1 | Divided clock, or the input clock while bypass is active |

## Verification
Two events can fall on the same input clock edge: the period boundary that loads an earlier pending commit, and a new commit write. The bench first sets up a long 16-cycle period and commits a short setting during its high phase. It then counts output samples so that it can place a second commit exactly in the last low cycle of that period. The outcome is judged at the ports. The next period must have the first committed lengths, the readback must show the second values still pending, and the period after that must have the second lengths with the commit flag cleared.

// File: rtl/wh_div_pkg.sv
package wh_div_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

endpackage

// File: rtl/wh_div_cfg.sv
module wh_div_cfg #(
  parameter int CNT_W = 4,
  localparam int REG_W = 2 * CNT_W + 2,
  localparam int BYP_BIT = 2 * CNT_W,
  localparam int CMT_BIT = 2 * CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             bnd_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [CNT_W-1:0] act_wait_o,
  output logic [CNT_W-1:0] act_hold_o,
  output logic             act_byp_o
);

  logic [CNT_W-1:0] stg_wait_q, stg_hold_q;
  logic             stg_byp_q;
  logic             pend_q;
  logic [CNT_W-1:0] act_wait_q, act_hold_q;
  logic             act_byp_q;

  logic commit_wr;
  logic load_now;

  assign commit_wr = we_i & wdata_i[CMT_BIT];
  assign load_now  = pend_q & bnd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_wait_q <= '0;
      stg_hold_q <= '0;
      stg_byp_q  <= 1'b0;
      pend_q     <= 1'b0;
      act_wait_q <= '0;
      act_hold_q <= '0;
      act_byp_q  <= 1'b0;
    end else begin
      if (we_i) begin
        stg_wait_q <= wdata_i[CNT_W-1:0];
        stg_hold_q <= wdata_i[2*CNT_W-1:CNT_W];
        stg_byp_q  <= wdata_i[BYP_BIT];
      end
      pend_q <= commit_wr | (pend_q & ~bnd_i);
      if (load_now) begin
        act_wait_q <= stg_wait_q;
        act_hold_q <= stg_hold_q;
        act_byp_q  <= stg_byp_q;
      end
    end
  end

  assign rdata_o    = {pend_q, stg_byp_q, stg_hold_q, stg_wait_q};
  assign act_wait_o = act_wait_q;
  assign act_hold_o = act_hold_q;
  assign act_byp_o  = act_byp_q;

  p_pend_set_r4: assert property (@(posedge clk) disable iff (rst)
    commit_wr |=> pend_q);

  p_pend_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_q && bnd_i && !commit_wr) |=> !pend_q);

  p_no_load_r3: assert property (@(posedge clk) disable iff (rst)
    !(pend_q && bnd_i) |=> $stable({act_wait_q, act_hold_q, act_byp_q}));

  p_load_old_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && bnd_i) |=> (act_wait_q == $past(stg_wait_q)) && (act_hold_q == $past(stg_hold_q)));

endmodule

// File: rtl/wh_div_phase.sv
module wh_div_phase #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wait_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic             byp_i,
  output logic             ph_o,
  output logic             bnd_o
);
  import wh_div_pkg::*;

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_high, end_low;

  assign end_high = (ph_q == PH_HIGH) && (cnt_q == wait_i);
  assign end_low  = (ph_q == PH_LOW) && (cnt_q == hold_i);
  assign bnd_o    = byp_i | end_low;
  assign ph_o     = (ph_q == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst || byp_i) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else if (end_high) begin
      ph_q  <= PH_LOW;
      cnt_q <= '0;
    end else if (end_low) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_high_limit_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HIGH) |-> (cnt_q <= wait_i));

  p_low_limit_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_LOW) |-> (cnt_q <= hold_i));

  p_fresh_high_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_o) |-> (cnt_q == '0));

  p_bypass_park_r7: assert property (@(posedge clk) disable iff (rst)
    byp_i |=> (ph_o && cnt_q == '0));

endmodule

// File: rtl/wh_clk_div.sv
module wh_clk_div #(
  parameter int CNT_W = 4,
  localparam int REG_W = 2 * CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             clk_out
);

  logic [CNT_W-1:0] act_wait, act_hold;
  logic             act_byp;
  logic             ph, bnd;

  wh_div_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we_i      (cfg_we),
    .wdata_i   (cfg_wdata),
    .bnd_i     (bnd),
    .rdata_o   (cfg_rdata),
    .act_wait_o(act_wait),
    .act_hold_o(act_hold),
    .act_byp_o (act_byp)
  );

  wh_div_phase #(.CNT_W(CNT_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .wait_i(act_wait),
    .hold_i(act_hold),
    .byp_i (act_byp),
    .ph_o  (ph),
    .bnd_o (bnd)
  );

  assign clk_out = act_byp ? clk : ph;

endmodule

// File: tb/wh_clk_div_tb.sv
module wh_clk_div_tb;
  localparam int CW = 4;
  localparam int RW = 2 * CW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [RW-1:0] wd = '0;
  logic [RW-1:0] rd;
  logic          co;

  int checks = 0;
  int errors = 0;
  logic          s;
  logic [RW-1:0] rs;

  always #10 clk = ~clk;

  wh_clk_div #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(we), .cfg_wdata(wd),
    .cfg_rdata(rd), .clk_out(co)
  );

  function automatic logic [RW-1:0] mk(bit c, bit b, int h, int w);
    return {c, b, CW'(h), CW'(w)};
  endfunction

  function automatic int rw_of(int r); return r / 2 - 1; endfunction
  function automatic int rh_of(int r); return r - rw_of(r) - 2; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    s  = co;
    rs = rd;
  endtask

  task automatic wr(logic [RW-1:0] d);
    we = 1'b1;
    wd = d;
    step();
    we = 1'b0;
  endtask

  task automatic wait_pend();
    for (int g = 0; g < 200 && rs[RW-1]; g++) step();
  endtask

  task automatic run_lengths(output int h, output int l);
    h = 0;
    l = 0;
    for (int g = 0; g < 200 && s === 1'b1; g++) begin h++; step(); end
    for (int g = 0; g < 200 && s === 1'b0; g++) begin l++; step(); end
  endtask

  task automatic measure(output int h, output int l);
    for (int g = 0; g < 200 && s !== 1'b0; g++) step();
    for (int g = 0; g < 200 && s !== 1'b1; g++) step();
    run_lengths(h, l);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h, l, r;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    step();
    rst = 1'b0;
    step();

    // R1 reset state
    chk("R1 readback", int'(rs), 0);
    measure(h, l);
    chk("R1 high", h, 1);
    chk("R1 low", l, 1);

    // R2 / R4 directed
    wr(mk(1, 0, 5, 3));
    chk("R4 pending set", int'(rs[RW-1]), 1);
    wait_pend();
    chk("R4 pending cleared", int'(rs[RW-1]), 0);
    measure(h, l);
    chk("R2 high", h, 4);
    chk("R2 low", l, 6);

    // R3 write without commit
    wr(mk(0, 0, 9, 2));
    chk("R3 readback", int'(rs), int'(mk(0, 0, 9, 2)));
    measure(h, l);
    chk("R3 high unchanged", h, 4);
    chk("R3 low unchanged", l, 6);

    // R5 commit mid-period
    for (int g = 0; g < 200 && s !== 1'b0; g++) step();
    for (int g = 0; g < 200 && s !== 1'b1; g++) step();
    wr(mk(1, 0, 1, 1));
    chk("R5 pending", int'(rs[RW-1]), 1);
    run_lengths(h, l);
    chk("R5 old high rest", h, 3);
    chk("R5 old low", l, 6);
    run_lengths(h, l);
    chk("R5 new high", h, 2);
    chk("R5 new low", l, 2);
    chk("R5 pending done", int'(rs[RW-1]), 0);

    // R8 corners and random ratios, with R3 writes mixed in
    for (int i = 0; i < 18; i++) begin
      r = (i == 0) ? 2 : (i == 1) ? 32 : int'($urandom_range(2, 32));
      wr(mk(1, 0, rh_of(r), rw_of(r)));
      wait_pend();
      if ($urandom_range(0, 1) == 1) begin
        wr(mk(0, 0, int'($urandom_range(0, 15)), int'($urandom_range(0, 15))));
        chk("R3 no pending", int'(rs[RW-1]), 0);
      end
      measure(h, l);
      chk("R8 high", h, r / 2);
      chk("R8 period", h + l, r);
    end

    // R9 commit landing on the loading boundary
    wr(mk(1, 0, 7, 7));
    wait_pend();
    for (int g = 0; g < 200 && s !== 1'b0; g++) step();
    for (int g = 0; g < 200 && s !== 1'b1; g++) step();
    wr(mk(1, 0, 1, 1));
    for (int g = 0; g < 14; g++) step();
    chk("R9 last low of old period", int'(s), 0);
    chk("R9 first still pending", int'(rs[RW-1]), 1);
    wr(mk(1, 0, 2, 3));
    chk("R9 second pending", int'(rs[RW-1]), 1);
    chk("R9 second staged", int'(rs[RW-2:0]), int'(mk(0, 0, 2, 3)));
    run_lengths(h, l);
    chk("R9 first high", h, 2);
    chk("R9 first low", l, 2);
    chk("R9 pending done", int'(rs[RW-1]), 0);
    run_lengths(h, l);
    chk("R9 second high", h, 4);
    chk("R9 second low", l, 3);

    // R6 bypass follows input clock
    wr(mk(1, 1, 9, 5));
    wait_pend();
    step();
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      chk("R6 high half", int'(co), 1);
      @(negedge clk); #5;
      chk("R6 low half", int'(co), 0);
    end
    step();

    // R7 leaving bypass
    wr(mk(1, 0, 2, 3));
    chk("R7 still bypassed", int'(s), 0);
    chk("R7 pending", int'(rs[RW-1]), 1);
    step();
    run_lengths(h, l);
    chk("R7 first high", h, 4);
    chk("R7 first low", l, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule